// File: doc/BRIEF.md
# Debug Address Watchpoint Match Unit

This block watches a stream of bus accesses against four programmable address slots. Each slot holds an address. A single packed control word sets each slot's enable bits, its access type and its region length. Every cycle the block may receive one access: an address, a size, a kind (instruction fetch, data read or data write) and a valid strobe. It compares the access against every enabled slot at once. Each slot that matches sets its own sticky bit in a status word.

Software programs the unit through a simple register write port. The port loads the four slot addresses, the control word and the status word. Software clears hit bits by writing the status word. The control word and status word are presented as registered outputs, so a debug monitor can sample them at any time.

Top module: `wp_match_unit`

## Requirements
- R1: After reset, `ctrl_word` and `stat_word` are zero. No slot reports a hit until it has been programmed.
- R2: A write with `reg_sel`=4 loads the control word. Bits 15:10 always read back as zero. Every other bit reads back as written. The exact-match flags are bits 8 and 9 and have no effect on matching.
- R3: Slot i is enabled when control bit 2i (local) or bit 2i+1 (global) is set. Either bit alone is enough. A slot with both bits clear never sets its hit bit.
- R4: Slot i's 4-bit field sits at control bits 16+4i. Bits 1:0 of the field are the type and bits 3:2 are the length. For type 00 (execute), a slot hits only on an instruction fetch (`acc_kind`=00) whose address equals the slot address exactly. Data accesses never hit it, and its length field is ignored.
- R5: Type 01 (write) hits only on data writes (`acc_kind`=10). It never hits on reads (`acc_kind`=01) or on fetches.
- R6: Type 11 (read-or-write) hits on data reads and on data writes, but not on fetches.
- R7: Type 10 (I/O) never hits, whatever the access.
- R8: For data types, the slot covers a naturally aligned region. The region is found by masking the slot address's low bits, by length code: 00 means 1 byte (0 bits), 01 means 2 bytes (1 bit), 11 means 4 bytes (2 bits), 10 means 8 bytes (3 bits). A data access covers 2^`acc_size` bytes starting at `acc_addr`. It hits when its byte range overlaps the slot's region.
- R9: Hit bits live in status bits 3:0, one bit per slot. They stay set until a write with `reg_sel`=5 loads bits 3:0 from `reg_wdata`. Status bits 31:4 always read zero.
- R10: When several slots match the same access, all of their hit bits are set on the same clock edge.
- R11: A hit appears in `stat_word` on the clock edge that samples the access. If a status write happens in the same cycle as a hit, the hit bit is still set after that edge.
- R12: An access presented with `acc_valid` low sets no hit bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0-3 slot address, 4 control, 5 status; other values are ignored |
| reg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Access valid strobe |
| acc_kind | input | 2 | Access kind: 00 fetch, 01 read, 10 write |
| acc_addr | input | ADDR_W | Access byte address |
| acc_size | input | 2 | Access size as log2 of bytes (0 to 3) |
| ctrl_word | output | 32 | Registered control word |
| stat_word | output | 32 | Registered status word (hit bits in 3:0) |

## Verification
Every result of this block arrives after exactly one register stage. A register write, or a hit caused by an access, is visible in `ctrl_word` or `stat_word` after the rising edge that samples it. Nothing changes earlier. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, so each read lands one edge after its stimulus. The latency scenario also samples the status word before that edge to confirm it has not changed early, and it combines a status write with a hit in the same cycle.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int NSLOT      = 4;
  localparam int CTRL_W     = 32;
  localparam int FIELD_BASE = 16;
  localparam int FIELD_W    = 4;
  localparam int SEL_W      = 3;

  localparam logic [SEL_W-1:0]  SEL_CTRL  = 3'd4;
  localparam logic [SEL_W-1:0]  SEL_STAT  = 3'd5;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 32'hFFFF_03FF;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10
  } acc_kind_e;

  typedef enum logic [1:0] {
    TY_EXEC = 2'b00,
    TY_WR   = 2'b01,
    TY_IO   = 2'b10,
    TY_RDWR = 2'b11
  } slot_type_e;

  // low-address mask for a slot length code (non-monotonic encoding)
  function automatic logic [2:0] len_mask(input logic [1:0] code);
    case (code)
      2'b00:   len_mask = 3'b000;
      2'b01:   len_mask = 3'b001;
      2'b11:   len_mask = 3'b011;
      default: len_mask = 3'b111;
    endcase
  endfunction

  // bytes-minus-one for an access size given as log2
  function automatic logic [2:0] size_span(input logic [1:0] lg);
    case (lg)
      2'd0:    size_span = 3'd0;
      2'd1:    size_span = 3'd1;
      2'd2:    size_span = 3'd3;
      default: size_span = 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/wp_regs.sv
module wp_regs
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_we,
  input  logic [SEL_W-1:0]             reg_sel,
  input  logic [CTRL_W-1:0]            reg_wdata,
  input  logic [NSLOT-1:0]             hit_vec,
  output logic [NSLOT-1:0][ADDR_W-1:0] slot_addr,
  output logic [CTRL_W-1:0]            ctrl_q,
  output logic [NSLOT-1:0]             stat_q
);
  logic [NSLOT-1:0] stat_base;

  for (genvar i = 0; i < NSLOT; i++) begin : g_addr
    always_ff @(posedge clk) begin
      if (rst)
        slot_addr[i] <= '0;
      else if (reg_we && reg_sel == SEL_W'(i))
        slot_addr[i] <= reg_wdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (reg_we && reg_sel == SEL_CTRL)
      ctrl_q <= reg_wdata & CTRL_KEEP;
  end

  // a software load never swallows a hit from the same cycle
  always_comb begin
    stat_base = stat_q;
    if (reg_we && reg_sel == SEL_STAT)
      stat_base = reg_wdata[NSLOT-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      stat_q <= '0;
    else
      stat_q <= stat_base | hit_vec;
  end
endmodule

// File: rtl/wp_slot_cmp.sv
module wp_slot_cmp
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               enable,
  input  logic [FIELD_W-1:0] field,
  input  logic [ADDR_W-1:0]  slot_addr,
  input  logic               acc_valid,
  input  logic [1:0]         acc_kind,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [1:0]         acc_size,
  output logic               hit
);
  localparam int XW = ADDR_W + 1;

  logic [1:0]    ty;
  logic [1:0]    len;
  logic [XW-1:0] rmask, aspan, rbase, rend, abeg, aend;
  logic          overlap, exact, kind_ok;

  assign ty  = field[1:0];
  assign len = field[3:2];

  always_comb begin
    rmask      = '0;
    rmask[2:0] = len_mask(len);
    aspan      = '0;
    aspan[2:0] = size_span(acc_size);
    rbase      = {1'b0, slot_addr} & ~rmask;
    rend       = rbase | rmask;
    abeg       = {1'b0, acc_addr};
    aend       = abeg + aspan;
    overlap    = (abeg <= rend) && (aend >= rbase);
    exact      = (acc_addr == slot_addr);
  end

  always_comb begin
    case (ty)
      TY_EXEC: kind_ok = (acc_kind == ACC_FETCH) && exact;
      TY_WR:   kind_ok = (acc_kind == ACC_WRITE) && overlap;
      TY_RDWR: kind_ok = ((acc_kind == ACC_WRITE) || (acc_kind == ACC_READ)) && overlap;
      default: kind_ok = 1'b0;
    endcase
  end

  assign hit = enable && acc_valid && kind_ok;
endmodule

// File: rtl/wp_match_unit.sv
module wp_match_unit
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  output logic [31:0]       ctrl_word,
  output logic [31:0]       stat_word
);
  logic [NSLOT-1:0][ADDR_W-1:0] slot_addr;
  logic [CTRL_W-1:0]            ctrl_q;
  logic [NSLOT-1:0]             stat_q;
  logic [NSLOT-1:0]             hit_vec;

  wp_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .hit_vec   (hit_vec),
    .slot_addr (slot_addr),
    .ctrl_q    (ctrl_q),
    .stat_q    (stat_q)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    wp_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .enable    (ctrl_q[2*i] | ctrl_q[2*i+1]),
      .field     (ctrl_q[FIELD_BASE+FIELD_W*i +: FIELD_W]),
      .slot_addr (slot_addr[i]),
      .acc_valid (acc_valid),
      .acc_kind  (acc_kind),
      .acc_addr  (acc_addr),
      .acc_size  (acc_size),
      .hit       (hit_vec[i])
    );
  end

  assign ctrl_word = ctrl_q;
  assign stat_word = {{(32-NSLOT){1'b0}}, stat_q};
endmodule

// File: rtl/wp_match_unit_chk.sv
module wp_match_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_we,
  input logic [2:0]  reg_sel,
  input logic        acc_valid,
  input logic [31:0] ctrl_word,
  input logic [31:0] stat_word
);
  logic stat_wr;
  assign stat_wr = reg_we && (reg_sel == 3'd5);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (ctrl_word == 32'h0) && (stat_word == 32'h0));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    ctrl_word[15:10] == 6'h0);

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> ((stat_word[3:0] & $past(stat_word[3:0])) == $past(stat_word[3:0])));

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
    stat_word[31:4] == 28'h0);

  a_r12_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && !stat_wr) |=> $stable(stat_word));

  for (genvar i = 0; i < 4; i++) begin : g_vac
    a_r3_vacant_quiet: assert property (@(posedge clk) disable iff (rst)
      ($rose(stat_word[i]) && !$past(stat_wr)) |->
        $past(ctrl_word[2*i] | ctrl_word[2*i+1]));
  end
endmodule

bind wp_match_unit wp_match_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .acc_valid (acc_valid),
  .ctrl_word (ctrl_word),
  .stat_word (stat_word)
);

// File: tb/wp_match_unit_tb.sv
module wp_match_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] ctrl_word, stat_word;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wp_match_unit #(.ADDR_W(32)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_size(acc_size),
    .ctrl_word(ctrl_word), .stat_word(stat_word)
  );

  localparam logic [1:0] K_F = 2'b00, K_R = 2'b01, K_W = 2'b10;

  function automatic logic [31:0] slot_cfg(int s, logic [1:0] en, logic [1:0] ty, logic [1:0] ln);
    logic [31:0] v = '0;
    v[2*s +: 2]    = en;
    v[16+4*s +: 4] = {ln, ty};
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic acc(logic [1:0] k, logic [31:0] a, logic [1:0] sz, logic v = 1'b1);
    @(negedge clk);
    acc_valid = v; acc_kind = k; acc_addr = a; acc_size = sz;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic clear_all();
    wr(3'd4, 32'h0);
    wr(3'd5, 32'h0);
  endtask

  task automatic t_reset();
    chk("R1 ctrl after reset", ctrl_word, 32'h0);
    chk("R1 stat after reset", stat_word, 32'h0);
  endtask

  task automatic t_ctrl();
    wr(3'd4, 32'hFFFF_FFFF);
    chk("R2 reserved bits zero", ctrl_word, 32'hFFFF_03FF);
    wr(3'd4, 32'h0000_0300);
    chk("R2 exact-match flags stored", ctrl_word, 32'h0000_0300);
    clear_all();
  endtask

  task automatic t_vacant();
    wr(3'd0, 32'h100);
    wr(3'd4, slot_cfg(0, 2'b00, 2'b11, 2'b00));
    acc(K_W, 32'h100, 0);
    chk("R3 vacant slot no hit", stat_word, 32'h0);
    wr(3'd4, slot_cfg(0, 2'b10, 2'b11, 2'b00));
    acc(K_W, 32'h100, 0);
    chk("R3 global enable alone hits", stat_word, 32'h1);
    clear_all();
  endtask

  task automatic t_exec();
    wr(3'd1, 32'h200);
    wr(3'd4, slot_cfg(1, 2'b01, 2'b00, 2'b11));
    acc(K_F, 32'h201, 0);
    chk("R4 fetch off by one no hit", stat_word, 32'h0);
    acc(K_R, 32'h200, 0);
    chk("R4 data read no hit on exec slot", stat_word, 32'h0);
    acc(K_F, 32'h200, 0);
    chk("R4 exact fetch hits", stat_word, 32'h2);
    clear_all();
  endtask

  task automatic t_write();
    wr(3'd2, 32'h300);
    wr(3'd4, slot_cfg(2, 2'b01, 2'b01, 2'b00));
    acc(K_R, 32'h300, 0);
    chk("R5 read no hit", stat_word, 32'h0);
    acc(K_F, 32'h300, 0);
    chk("R5 fetch no hit", stat_word, 32'h0);
    acc(K_W, 32'h300, 0);
    chk("R5 write hits", stat_word, 32'h4);
    clear_all();
  endtask

  task automatic t_rdwr();
    wr(3'd3, 32'h400);
    wr(3'd4, slot_cfg(3, 2'b01, 2'b11, 2'b00));
    acc(K_F, 32'h400, 0);
    chk("R6 fetch no hit", stat_word, 32'h0);
    acc(K_R, 32'h400, 0);
    chk("R6 read hits", stat_word, 32'h8);
    wr(3'd5, 32'h0);
    acc(K_W, 32'h400, 0);
    chk("R6 write hits", stat_word, 32'h8);
    clear_all();
  endtask

  task automatic t_io();
    wr(3'd0, 32'h500);
    wr(3'd4, slot_cfg(0, 2'b11, 2'b10, 2'b00));
    acc(K_W, 32'h500, 0);
    acc(K_R, 32'h500, 0);
    acc(K_F, 32'h500, 0);
    chk("R7 io type never hits", stat_word, 32'h0);
    clear_all();
  endtask

  task automatic t_len();
    wr(3'd0, 32'h1005);
    wr(3'd4, slot_cfg(0, 2'b01, 2'b01, 2'b10));
    acc(K_W, 32'h1007, 0);
    chk("R8 8B region top byte hits", stat_word, 32'h1);
    wr(3'd5, 0);
    acc(K_W, 32'h1008, 0);
    chk("R8 8B region past end no hit", stat_word, 32'h0);
    acc(K_W, 32'h0FFF, 0);
    chk("R8 8B region below base no hit", stat_word, 32'h0);
    acc(K_W, 32'h0FFE, 2);
    chk("R8 4B access straddling base hits", stat_word, 32'h1);
    wr(3'd5, 0);
    wr(3'd4, slot_cfg(0, 2'b01, 2'b01, 2'b01));
    acc(K_W, 32'h1006, 0);
    chk("R8 2B region outside no hit", stat_word, 32'h0);
    acc(K_W, 32'h1004, 0);
    chk("R8 2B region low byte hits", stat_word, 32'h1);
    wr(3'd5, 0);
    wr(3'd4, slot_cfg(0, 2'b01, 2'b01, 2'b11));
    acc(K_W, 32'h1003, 0);
    acc(K_W, 32'h1008, 0);
    chk("R8 4B region outside no hit", stat_word, 32'h0);
    acc(K_W, 32'h1007, 0);
    chk("R8 4B region top byte hits", stat_word, 32'h1);
    clear_all();
  endtask

  task automatic t_sticky();
    wr(3'd1, 32'h600);
    wr(3'd4, slot_cfg(1, 2'b01, 2'b11, 2'b00));
    acc(K_R, 32'h600, 0);
    repeat (3) @(negedge clk);
    acc(K_R, 32'h700, 0);
    chk("R9 hit stays set", stat_word, 32'h2);
    wr(3'd5, 32'h0);
    chk("R9 status write clears", stat_word, 32'h0);
    wr(3'd5, 32'hFFFF_FFFF);
    chk("R9 upper status bits zero", stat_word, 32'hF);
    clear_all();
  endtask

  task automatic t_multi();
    wr(3'd0, 32'h800);
    wr(3'd2, 32'h800);
    wr(3'd4, slot_cfg(0, 2'b01, 2'b11, 2'b00) | slot_cfg(2, 2'b10, 2'b01, 2'b00));
    acc(K_W, 32'h800, 0);
    chk("R10 two slots hit together", stat_word, 32'h5);
    clear_all();
  endtask

  task automatic t_latency();
    wr(3'd3, 32'h900);
    wr(3'd4, slot_cfg(3, 2'b01, 2'b11, 2'b00));
    wr(3'd5, 32'h1);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = K_R; acc_addr = 32'h900; acc_size = 0;
    reg_we = 1'b1; reg_sel = 3'd5; reg_wdata = 32'h0;
    #1;
    chk("R11 no early change", stat_word, 32'h1);
    @(negedge clk);
    acc_valid = 1'b0; reg_we = 1'b0;
    chk("R11 hit kept over status write", stat_word, 32'h8);
    clear_all();
  endtask

  task automatic t_novalid();
    wr(3'd0, 32'hA00);
    wr(3'd4, slot_cfg(0, 2'b01, 2'b11, 2'b00));
    acc(K_W, 32'hA00, 0, 1'b0);
    chk("R12 invalid access no hit", stat_word, 32'h0);
    clear_all();
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL ALL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl();
    t_vacant();
    t_exec();
    t_write();
    t_rdwr();
    t_io();
    t_len();
    t_sticky();
    t_multi();
    t_latency();
    t_novalid();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule